// File: doc/BRIEF.md
# Prescaled Two-Channel Pulse Width Modulator

This block produces one or two pulse-width-modulated outputs from a system clock. Each channel first divides the clock by a 6-bit prescale value plus one, which gives one tick. It then counts ticks through a 10-bit period. The output is high for the first DC ticks of every period and low for the rest. A separate flag in the duty register forces the output high for the whole period. Software programs each channel through a small word-addressed register bus. A per-channel enable pin starts and stops the waveform.

A new prescale, duty or period value does not change a running period. The channel takes all three values together at the next period boundary. A bit in the control register selects how the channel stops when its enable falls. With the bit clear, the channel finishes the current period and then goes low. With the bit set, the output goes low on the next cycle. The second channel has its own register bank at byte offset 0x10 and is built only when a parameter asks for it.

Top module: `pwm_dual_bank`

## Requirements
- R1: While a channel is enabled, one output period lasts (P+1)×(V+1) clock cycles. P is control bits [5:0] and V is period bits [9:0].
- R2: Each period starts with the output high for (P+1)×DC cycles, followed by low for the rest of the period. DC is duty bits [9:0].
- R3: When duty bit 10 (full flag) is set, the output is high for the whole period. When DC is 0 and the flag is clear, the output stays low.
- R4: When DC is greater than V, the output is high for the whole period.
- R5: The channel takes new P, DC, full-flag and V values only at a period boundary. A write during a period leaves that period unchanged.
- R6: When control bit 6 is 0 and the enable falls, the current period completes. The output is low from the cycle after the period's last cycle.
- R7: When control bit 6 is 1 and the enable falls, the output is low from the cycle after the edge that samples the low enable.
- R8: A disabled channel drives its output low and holds its counters at zero. After the enable is sampled high, the next cycle is cycle 0 of a fresh period.
- R9: Register offsets are 0x00 control, 0x04 duty and 0x08 period. Reads return the bits last written: control bits [6:0], duty bits [10:0] and period bits [9:0]. All other bits read 0, and offsets 0x0C and 0x1C read 0.
- R10: Channel 1 repeats the same register layout at 0x10, 0x14 and 0x18 and runs independently of channel 0. When the channel-1 parameter is off, its offsets read 0 and its output stays low.
- R11: After reset, all registers read 0 and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 5 | Byte address of the register; bits [1:0] are ignored |
| we | input | 1 | Write strobe, sampled on the rising clock edge |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| ch_en | input | 2 | Per-channel run enable |
| pwm_out | output | 2 | Per-channel PWM output |

## Verification
The assertions check four things on every cycle. The prescale and period counters stay within the bounds of the active configuration. The active configuration changes only on a period-boundary edge. An abrupt stop always ends the run on the next edge. A graceful stop never ends the run before the boundary. The bench shows the shape of the waveform itself: period length, high time, the full-duty and DC-above-period cases, and the exact cycle at which a mid-period update first appears. It does this by sweeping small prescale, period and duty values and comparing every output cycle with an arithmetic model. Register readback, independence between the channels and the two stop modes are covered by directed scenarios.

// File: rtl/pwmd_pkg.sv
package pwmd_pkg;
  localparam int PRE_W      = 6;
  localparam int PER_W      = 10;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 5;
  localparam int MAX_CH     = 2;
  localparam int ABRUPT_BIT = PRE_W;
  localparam int FULL_BIT   = PER_W;

  typedef enum logic [1:0] {
    W_CTRL  = 2'd0,
    W_DUTY  = 2'd1,
    W_PER   = 2'd2,
    W_RSVD  = 2'd3
  } pwmd_word_e;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic             abrupt;
    logic [PER_W-1:0] dc;
    logic             full;
    logic [PER_W-1:0] pv;
  } pwmd_cfg_t;
endpackage

// File: rtl/pwmd_regbank.sv
module pwmd_regbank
  import pwmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        word,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output pwmd_cfg_t         cfg
);
  pwmd_cfg_t regs;
  logic      unused_wdata;

  assign unused_wdata = ^wdata[DATA_W-1:FULL_BIT+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs <= '0;
    end else if (wr) begin
      unique case (pwmd_word_e'(word))
        W_CTRL: begin
          regs.pre    <= wdata[PRE_W-1:0];
          regs.abrupt <= wdata[ABRUPT_BIT];
        end
        W_DUTY: begin
          regs.dc   <= wdata[PER_W-1:0];
          regs.full <= wdata[FULL_BIT];
        end
        W_PER:   regs.pv <= wdata[PER_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    unique case (pwmd_word_e'(word))
      W_CTRL: begin
        rdata[PRE_W-1:0]  = regs.pre;
        rdata[ABRUPT_BIT] = regs.abrupt;
      end
      W_DUTY: begin
        rdata[PER_W-1:0] = regs.dc;
        rdata[FULL_BIT]  = regs.full;
      end
      W_PER:   rdata[PER_W-1:0] = regs.pv;
      default: rdata = '0;
    endcase
  end

  assign cfg = regs;
endmodule

// File: rtl/pwmd_channel.sv
module pwmd_channel
  import pwmd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  pwmd_cfg_t cfg,
  output logic      pwm
);
  logic             run;
  logic [PRE_W-1:0] pc;
  logic [PER_W-1:0] cnt;
  logic [PRE_W-1:0] act_pre;
  logic [PER_W-1:0] act_pv;
  logic [PER_W-1:0] act_dc;
  logic             act_full;
  logic             tick_end;
  logic             boundary;

  assign tick_end = (pc == act_pre);
  assign boundary = tick_end && (cnt == act_pv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      pc       <= '0;
      cnt      <= '0;
      act_pre  <= '0;
      act_pv   <= '0;
      act_dc   <= '0;
      act_full <= 1'b0;
    end else if (!run) begin
      pc  <= '0;
      cnt <= '0;
      if (en) begin
        run      <= 1'b1;
        act_pre  <= cfg.pre;
        act_pv   <= cfg.pv;
        act_dc   <= cfg.dc;
        act_full <= cfg.full;
      end
    end else if (!en && cfg.abrupt) begin
      run <= 1'b0;
      pc  <= '0;
      cnt <= '0;
    end else if (!tick_end) begin
      pc <= pc + 1'b1;
    end else begin
      pc <= '0;
      if (!boundary) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt      <= '0;
        act_pre  <= cfg.pre;
        act_pv   <= cfg.pv;
        act_dc   <= cfg.dc;
        act_full <= cfg.full;
        if (!en) run <= 1'b0;
      end
    end
  end

  assign pwm = run && (act_full || (cnt < act_dc));

  // R1: counters never pass the active limits
  assert_counter_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (pc <= act_pre) && (cnt <= act_pv));

  // R5: active configuration moves only across a boundary edge
  assert_shadow_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !boundary) |=> ($stable(act_pre) && $stable(act_pv) &&
                            $stable(act_dc) && $stable(act_full)));

  // R7: abrupt stop ends the run on the next edge
  assert_abrupt_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !en && cfg.abrupt) |=> !run);

  // R6: graceful stop keeps running until the boundary
  assert_graceful_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cfg.abrupt && !boundary) |=> run);
endmodule

// File: rtl/pwm_dual_bank.sv
module pwm_dual_bank
  import pwmd_pkg::*;
#(
  parameter bit HAS_CH1 = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [MAX_CH-1:0] ch_en,
  output logic [MAX_CH-1:0] pwm_out
);
  localparam int NCH = HAS_CH1 ? 2 : 1;

  logic              ch_sel;
  logic [1:0]        word;
  logic [DATA_W-1:0] rd [MAX_CH];
  pwmd_cfg_t         cfg [MAX_CH];
  logic              unused_lsb;

  assign ch_sel     = addr[ADDR_W-1];
  assign word       = addr[3:2];
  assign unused_lsb = ^addr[1:0];

  for (genvar i = 0; i < MAX_CH; i++) begin : g_ch
    if (i < NCH) begin : g_on
      logic wr_i;
      assign wr_i = we && (ch_sel == i[0]);

      pwmd_regbank u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_i),
        .word  (word),
        .wdata (wdata),
        .rdata (rd[i]),
        .cfg   (cfg[i])
      );

      pwmd_channel u_chan (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ch_en[i]),
        .cfg   (cfg[i]),
        .pwm   (pwm_out[i])
      );
    end else begin : g_off
      logic unused_en;
      assign unused_en  = ch_en[i];
      assign rd[i]      = '0;
      assign cfg[i]     = '0;
      assign pwm_out[i] = 1'b0;
    end
  end

  assign rdata = rd[ch_sel];
endmodule

// File: tb/tb_pwm_dual_bank.sv
`timescale 1ns/100ps
module tb_pwm_dual_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  ch_en = '0;
  logic [1:0]  pwm_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pwm_dual_bank dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata),
    .rdata(rdata), .ch_en(ch_en), .pwm_out(pwm_out)
  );

  function automatic bit model(int p, int v, int d, int f, int t);
    int len = (p + 1) * (v + 1);
    int ph  = t % len;
    return (f != 0) || ((ph / (p + 1)) < d);
  endfunction

  task automatic chk(string req, int t, logic act, logic exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: t=%0d got %0b exp %0b", req, t, act, exp_v);
    end
  endtask

  task automatic chk32(string req, logic [31:0] act, logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: got %h exp %h", req, act, exp_v);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [4:0] a, logic [31:0] exp_v);
    @(negedge clk);
    addr = a;
    #1;
    chk32(req, rdata, exp_v);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 out0", 0, pwm_out[0], 1'b0);
    chk("R11 out1", 0, pwm_out[1], 1'b0);
    rst_n = 1'b1;
    for (int a = 0; a < 32; a += 4) rd_chk("R11 reg", a[4:0], 32'h0);

    // R9 / R10: readback masks and reserved words
    wr(5'h00, 32'hFFFF_FFFF); wr(5'h04, 32'hFFFF_FFFF);
    wr(5'h08, 32'hFFFF_FFFF); wr(5'h0C, 32'hFFFF_FFFF);
    rd_chk("R9 ctrl", 5'h00, 32'h7F);
    rd_chk("R9 duty", 5'h04, 32'h7FF);
    rd_chk("R9 per",  5'h08, 32'h3FF);
    rd_chk("R9 rsvd", 5'h0C, 32'h0);
    rd_chk("R10 ch1 untouched", 5'h10, 32'h0);
    wr(5'h10, 32'h25); wr(5'h14, 32'h403); wr(5'h18, 32'h2A5);
    rd_chk("R10 ctrl1", 5'h10, 32'h25);
    rd_chk("R10 duty1", 5'h14, 32'h403);
    rd_chk("R10 per1",  5'h18, 32'h2A5);
    rd_chk("R10 rsvd1", 5'h1C, 32'h0);
    rd_chk("R10 ch0 kept", 5'h00, 32'h7F);

    // R1 R2 R3 R4 R8: sweep of small configurations on channel 0
    for (int p = 0; p < 3; p++)
      for (int v = 0; v < 4; v++)
        for (int d = 0; d < 6; d++)
          for (int f = 0; f < 2; f++) begin
            @(negedge clk); ch_en[0] = 1'b0;
            wr(5'h00, 32'h40 | p);
            wr(5'h04, (f << 10) | d);
            wr(5'h08, v);
            chk("R8 idle low", -1, pwm_out[0], 1'b0);
            ch_en[0] = 1'b1;
            for (int t = 0; t < 2 * (p + 1) * (v + 1); t++) begin
              @(negedge clk);
              chk(f != 0 ? "R3" : (d > v ? "R4" : "R1/R2"), t, pwm_out[0],
                  model(p, v, d, f, t));
            end
          end
    @(negedge clk); ch_en[0] = 1'b0;

    // R5: mid-period update takes effect at the boundary
    wr(5'h00, 32'h01); wr(5'h04, 32'h2); wr(5'h08, 32'h3);
    @(negedge clk); ch_en[0] = 1'b1;
    for (int t = 0; t < 20; t++) begin
      @(negedge clk);
      chk("R5", t, pwm_out[0], t < 8 ? model(1, 3, 2, 0, t) : model(0, 5, 3, 0, t - 8));
      if (t == 2) begin addr = 5'h04; wdata = 32'h3; we = 1'b1; end
      if (t == 3) begin addr = 5'h08; wdata = 32'h5; end
      if (t == 4) begin addr = 5'h00; wdata = 32'h0; end
      if (t == 5) we = 1'b0;
    end

    // R6: graceful stop completes the period
    wr(5'h00, 32'h01); wr(5'h04, 32'h2); wr(5'h08, 32'h3);
    @(negedge clk); ch_en[0] = 1'b0;
    repeat (12) @(negedge clk);
    chk("R6 idle", -1, pwm_out[0], 1'b0);
    ch_en[0] = 1'b1;
    for (int t = 0; t < 14; t++) begin
      @(negedge clk);
      chk("R6", t, pwm_out[0], t < 8 ? model(1, 3, 2, 0, t) : 1'b0);
      if (t == 3) ch_en[0] = 1'b0;
    end

    // R7: abrupt stop
    wr(5'h00, 32'h41);
    ch_en[0] = 1'b1;
    for (int t = 0; t < 6; t++) begin
      @(negedge clk);
      chk("R7", t, pwm_out[0], t < 2 ? model(1, 3, 2, 0, t) : 1'b0);
      if (t == 1) ch_en[0] = 1'b0;
    end

    // R10: both channels running at once with different settings
    wr(5'h00, 32'h42); wr(5'h04, 32'h1); wr(5'h08, 32'h1);
    wr(5'h10, 32'h40); wr(5'h14, 32'h2); wr(5'h18, 32'h4);
    @(negedge clk); ch_en = 2'b11;
    for (int t = 0; t < 30; t++) begin
      @(negedge clk);
      chk("R10 ch0", t, pwm_out[0], model(2, 1, 1, 0, t));
      chk("R10 ch1", t, pwm_out[1], model(0, 4, 2, 0, t));
    end
    @(negedge clk); ch_en = 2'b00;
    @(negedge clk);
    chk("R8 both low", -1, pwm_out[0] | pwm_out[1], 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule